// File: doc/BRIEF.md
# Configuration Readback Fault Injector

This block lets a debug path plant deliberate byte errors in the readback stream of a configuration-integrity checker, so the checker's detection logic can be tested in place. A 21-bit injection word is shifted in serially on a test-access shift strobe. An update strobe then captures it into a staging register and raises a pending flag. The staged word moves into the active register only outside the protected window. That window covers both the final frame and the first frame of a readback pass, so an injection is never half-applied to a frame in flight.

The active word is laid out as follows. Bits 20:19 are the injection type, bits 18:8 are the target byte index within the first frame, and bits 7:0 are the XOR mask. Readback bytes flow through as a valid/ready stream with no storage. The output beat is valid in the same cycle as the input beat, and back-pressure from the consumer reaches the producer unchanged in that same cycle. While a beat belongs to the first frame and its index matches the target, the mask is XORed into its data.

Top module: `fault_inject_ctrl`

## Requirements
- R1: After reset the active word is all zeros, meaning no injection, and `word_pending` is 0; output data equals input data.
- R2: Each cycle with `tap_shift` high shifts `tap_sdi` into the shift register so that the first bit shifted lands in bit 0 after 21 shifts; `tap_update` copies the shift register into the staging register and sets `word_pending`.
- R3: `out_valid` equals `rb_valid` and `rb_ready` equals `out_ready` in the same cycle; a beat moves only when both are high, and the data path holds no state.
- R4: With type 01 (single byte), a first-frame beat whose `byte_idx` equals the target index leaves with data XOR mask; other indices pass unchanged.
- R5: While `first_frame` or `last_frame` is high, the active word does not change; the staged word is taken on the first clock edge at which both are low.
- R6: `word_pending` clears on the edge at which the active register takes the staged word.
- R7: Beats with `first_frame` low always pass unchanged.
- R8: `tap_update` is ignored while `user_mode` is low: `word_pending` stays 0 and the active word is unchanged.
- R9: With type 10 (double adjacent), the mask is XORed into the first-frame bytes at the target index and at target index + 1; the sum does not wrap.
- R10: Type 00 and type 11 both inject nothing.
- R11: An active word stays in force for every later pass over the first frame until a new word replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_mode | input | 1 | High while the device is in normal operation; gates arming |
| tap_shift | input | 1 | Shift strobe for the serial injection word |
| tap_update | input | 1 | Capture strobe for the staging register |
| tap_sdi | input | 1 | Serial data, first bit is word bit 0 |
| first_frame | input | 1 | Current readback frame is the first one |
| last_frame | input | 1 | Current readback frame is the final one |
| byte_idx | input | 11 | Byte index of the beat within its frame |
| rb_valid | input | 1 | Readback beat valid |
| rb_ready | output | 1 | Readback beat accepted when high with `rb_valid` |
| rb_data | input | 8 | Readback byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready for output beat |
| out_data | output | 8 | Readback byte after injection |
| word_pending | output | 1 | Staged word waiting for transfer to the active register |

## Verification
The data path is combinational, so the bench applies each beat on the falling edge and samples `out_data`, `out_valid` and `rb_ready` shortly after, in the same low phase. `word_pending` rises on the rising edge that samples `tap_update`. The active word changes on the next rising edge at which both frame flags are low, so a word loaded outside the window is in force two edges after the update strobe. The bench checks for the new word only after that edge. Window tests hold a frame flag high across several edges and confirm that the old word is still applied before the flag is released.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic [1:0] {
    INJ_NONE   = 2'b00,
    INJ_SINGLE = 2'b01,
    INJ_DOUBLE = 2'b10,
    INJ_BAD    = 2'b11
  } inj_kind_e;

  localparam int KIND_W = 2;

  // Map raw type bits to an injection kind; the reserved code acts as none.
  function automatic inj_kind_e decode_kind(input logic [KIND_W-1:0] raw);
    case (raw)
      2'b01:   return INJ_SINGLE;
      2'b10:   return INJ_DOUBLE;
      default: return INJ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fic_shift_stage.sv
module fic_shift_stage #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              shift_en,
  input  logic              sdi,
  input  logic              update_en,
  input  logic              take,
  output logic [WORD_W-1:0] staged_word,
  output logic              pending
);
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shift_en) begin
      shreg_q <= {sdi, shreg_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_word <= '0;
      pending     <= 1'b0;
    end else if (update_en && user_mode) begin
      staged_word <= shreg_q;
      pending     <= 1'b1;
    end else if (take) begin
      pending     <= 1'b0;
    end
  end
endmodule

// File: rtl/fic_arm_reg.sv
module fic_arm_reg #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              in_window,
  input  logic [WORD_W-1:0] staged_word,
  output logic              take,
  output logic [WORD_W-1:0] active_word
);
  assign take = pending && !in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_word <= '0;
    end else if (take) begin
      active_word <= staged_word;
    end
  end
endmodule

// File: rtl/fic_byte_corrupter.sv
module fic_byte_corrupter
  import fic_pkg::*;
#(
  parameter int LOC_W  = 11,
  parameter int BYTE_W = 8
) (
  input  logic [KIND_W-1:0] kind_raw,
  input  logic [LOC_W-1:0]  target_loc,
  input  logic [BYTE_W-1:0] mask,
  input  logic              first_frame,
  input  logic [LOC_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] data_out
);
  localparam int SUM_W = LOC_W + 1;

  inj_kind_e         kind;
  logic [SUM_W-1:0]  next_loc;
  logic              hit_base;
  logic              hit_next;
  logic              apply;

  always_comb begin
    kind     = decode_kind(kind_raw);
    next_loc = {1'b0, target_loc} + SUM_W'(1);
    hit_base = (byte_idx == target_loc);
    hit_next = ({1'b0, byte_idx} == next_loc);
    case (kind)
      INJ_SINGLE: apply = first_frame && hit_base;
      INJ_DOUBLE: apply = first_frame && (hit_base || hit_next);
      default:    apply = 1'b0;
    endcase
    data_out = apply ? (data_in ^ mask) : data_in;
  end
endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
  import fic_pkg::*;
#(
  parameter int LOC_W  = 11,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              tap_shift,
  input  logic              tap_update,
  input  logic              tap_sdi,
  input  logic              first_frame,
  input  logic              last_frame,
  input  logic [LOC_W-1:0]  byte_idx,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [BYTE_W-1:0] rb_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              word_pending
);
  localparam int WORD_W  = KIND_W + LOC_W + BYTE_W;
  localparam int LOC_LSB = BYTE_W;
  localparam int KIND_LSB = BYTE_W + LOC_W;

  logic [WORD_W-1:0] staged_word;
  logic [WORD_W-1:0] active_q;
  logic              take;
  logic              in_window;

  assign in_window = first_frame || last_frame;

  fic_shift_stage #(.WORD_W(WORD_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .user_mode   (user_mode),
    .shift_en    (tap_shift),
    .sdi         (tap_sdi),
    .update_en   (tap_update),
    .take        (take),
    .staged_word (staged_word),
    .pending     (word_pending)
  );

  fic_arm_reg #(.WORD_W(WORD_W)) u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending     (word_pending),
    .in_window   (in_window),
    .staged_word (staged_word),
    .take        (take),
    .active_word (active_q)
  );

  fic_byte_corrupter #(.LOC_W(LOC_W), .BYTE_W(BYTE_W)) u_corrupt (
    .kind_raw    (active_q[KIND_LSB +: KIND_W]),
    .target_loc  (active_q[LOC_LSB +: LOC_W]),
    .mask        (active_q[BYTE_W-1:0]),
    .first_frame (first_frame),
    .byte_idx    (byte_idx),
    .data_in     (rb_data),
    .data_out    (out_data)
  );

  assign out_valid = rb_valid;
  assign rb_ready  = out_ready;
endmodule

// File: rtl/fault_inject_ctrl_chk.sv
module fault_inject_ctrl_chk #(
  parameter int WORD_W = 21,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              user_mode,
  input logic              tap_update,
  input logic              first_frame,
  input logic              last_frame,
  input logic              rb_valid,
  input logic              rb_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] rb_data,
  input logic [BYTE_W-1:0] out_data,
  input logic              word_pending,
  input logic [WORD_W-1:0] active_word
);
  logic [1:0] kind_bits;
  assign kind_bits = active_word[WORD_W-1 -: 2];

  a_r3_stream_link: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == rb_valid) && (rb_ready == out_ready));

  a_r5_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (first_frame || last_frame) |=> $stable(active_word));

  a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (word_pending && !first_frame && !last_frame && !tap_update) |=> !word_pending);

  a_r7_pass_outside_first: assert property (@(posedge clk) disable iff (!rst_n)
    !first_frame |-> (out_data == rb_data));

  a_r8_no_arm_outside_user: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && !word_pending) |=> !word_pending);

  a_r10_inert_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_bits == 2'b00 || kind_bits == 2'b11) |-> (out_data == rb_data));
endmodule

bind fault_inject_ctrl fault_inject_ctrl_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .user_mode    (user_mode),
  .tap_update   (tap_update),
  .first_frame  (first_frame),
  .last_frame   (last_frame),
  .rb_valid     (rb_valid),
  .rb_ready     (rb_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .rb_data      (rb_data),
  .out_data     (out_data),
  .word_pending (word_pending),
  .active_word  (active_q)
);

// File: tb/sim_fault_inject_ctrl.sv
`timescale 1ns/1ps
module sim_fault_inject_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        user_mode = 1'b1;
  logic        tap_shift = 1'b0, tap_update = 1'b0, tap_sdi = 1'b0;
  logic        first_frame = 1'b0, last_frame = 1'b0;
  logic [10:0] byte_idx = '0;
  logic        rb_valid = 1'b0, out_ready = 1'b1;
  logic [7:0]  rb_data = '0;
  logic        rb_ready, out_valid, word_pending;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fault_inject_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .tap_shift(tap_shift), .tap_update(tap_update), .tap_sdi(tap_sdi),
    .first_frame(first_frame), .last_frame(last_frame), .byte_idx(byte_idx),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_data(rb_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .word_pending(word_pending)
  );

  // Vector: {first_frame, byte_idx[10:0], data_in[7:0], expected[7:0]}
  // Active word for this table: type 01, target 5, mask A5.
  localparam int NVEC = 6;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 11'd5, 8'h00, 8'hA5},
    {1'b1, 11'd4, 8'h3C, 8'h3C},
    {1'b1, 11'd6, 8'hFF, 8'hFF},
    {1'b0, 11'd5, 8'h12, 8'h12},
    {1'b1, 11'd5, 8'hA5, 8'h00},
    {1'b0, 11'd0, 8'h77, 8'h77}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] mkword(input logic [1:0] t, input logic [10:0] loc, input logic [7:0] m);
    return {t, loc, m};
  endfunction

  // Shift the word LSB first, then pulse update; returns on the negedge after the update edge.
  task automatic load_word(input logic [20:0] w);
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      tap_shift = 1'b1;
      tap_sdi   = w[i];
    end
    @(negedge clk);
    tap_shift  = 1'b0;
    tap_update = 1'b1;
    @(negedge clk);
    tap_update = 1'b0;
  endtask

  task automatic beat(input logic ff, input logic [10:0] idx, input logic [7:0] d);
    first_frame = ff;
    byte_idx    = idx;
    rb_data     = d;
    rb_valid    = 1'b1;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    beat(1'b1, 11'd0, 8'h5A);
    check("R1 pending", word_pending, 0);
    check("R1 data", out_data, 8'h5A);
    rst_n = 1'b1;
    @(negedge clk);
    beat(1'b1, 11'd0, 8'hC3);
    check("R1 no injection", out_data, 8'hC3);

    // R3: stream link in both directions
    rb_valid = 1'b0; out_ready = 1'b0; #1;
    check("R3 valid low", out_valid, 0);
    check("R3 ready low", rb_ready, 0);
    rb_valid = 1'b1; out_ready = 1'b1; #1;
    check("R3 valid high", out_valid, 1);
    check("R3 ready high", rb_ready, 1);

    // R2/R4: load single-byte word outside window
    first_frame = 1'b0;
    load_word(mkword(2'b01, 11'd5, 8'hA5));
    check("R2 pending set", word_pending, 1);
    @(negedge clk);
    check("R6 pending cleared", word_pending, 0);

    // Vector table: R4 and R7
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      beat(VEC[v][27], VEC[v][26:16], VEC[v][15:8]);
      check(VEC[v][27] ? "R4 table" : "R7 table", out_data, VEC[v][7:0]);
      check("R3 table valid", out_valid, 1);
    end

    // R5: window held by first_frame; new double word stays staged
    @(negedge clk);
    first_frame = 1'b1;
    load_word(mkword(2'b10, 11'd7, 8'h0F));
    repeat (3) @(negedge clk);
    check("R5 still pending", word_pending, 1);
    beat(1'b1, 11'd5, 8'h00);
    check("R5 old word active", out_data, 8'hA5);
    // last_frame alone also holds the window
    first_frame = 1'b0; last_frame = 1'b1;
    @(negedge clk);
    check("R5 last_frame holds", word_pending, 1);
    last_frame = 1'b0;
    @(negedge clk);
    check("R6 taken after window", word_pending, 0);

    // R9: double adjacent
    beat(1'b1, 11'd7, 8'h00); check("R9 base", out_data, 8'h0F);
    beat(1'b1, 11'd8, 8'hF0); check("R9 next", out_data, 8'hFF);
    beat(1'b1, 11'd9, 8'h11); check("R9 beyond", out_data, 8'h11);
    beat(1'b1, 11'd5, 8'h00); check("R9 old target", out_data, 8'h00);

    // R11: second pass over first frame still injects
    first_frame = 1'b0;
    repeat (4) @(negedge clk);
    beat(1'b1, 11'd8, 8'h00); check("R11 second pass", out_data, 8'h0F);

    // R9: top index, no wrap to 0
    first_frame = 1'b0;
    load_word(mkword(2'b10, 11'd2047, 8'h3C));
    @(negedge clk);
    beat(1'b1, 11'd2047, 8'h00); check("R9 top index", out_data, 8'h3C);
    beat(1'b1, 11'd0, 8'h00); check("R9 no wrap", out_data, 8'h00);

    // R10: reserved type 11
    first_frame = 1'b0;
    load_word(mkword(2'b11, 11'd3, 8'hFF));
    @(negedge clk);
    beat(1'b1, 11'd3, 8'h44); check("R10 type 11", out_data, 8'h44);
    beat(1'b1, 11'd4, 8'h44); check("R10 type 11 next", out_data, 8'h44);

    // R8: update ignored outside user mode (load single word first)
    first_frame = 1'b0;
    load_word(mkword(2'b01, 11'd3, 8'h81));
    @(negedge clk);
    user_mode = 1'b0;
    load_word(mkword(2'b01, 11'd9, 8'hFF));
    check("R8 no pending", word_pending, 0);
    @(negedge clk);
    beat(1'b1, 11'd9, 8'h00); check("R8 word not taken", out_data, 8'h00);
    beat(1'b1, 11'd3, 8'h00); check("R8 old word kept", out_data, 8'h81);
    user_mode = 1'b1;

    // R10/R11: type 00 disarms
    first_frame = 1'b0;
    load_word(mkword(2'b00, 11'd3, 8'h81));
    @(negedge clk);
    beat(1'b1, 11'd3, 8'h00); check("R10 type 00", out_data, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule